// File: doc/BRIEF.md
# Key-Gated System Control Register Bank

This block is the control register file of a processor module. A host reads and writes 32-bit words over a plain word-addressed bus with separate read and write strobes. The bank holds two oscillator setting words, a control word, SDRAM and initialisation configuration words, and two flag words. Each flag word has one address that sets bits and one that clears them. A free-running reference counter can be read as a timestamp. A read-only window returns the memory module's presence-detect bytes.

The two oscillator words are protected by a key. A write to either one takes effect only while the lock word holds the key value 0xA05F. When the key is present, the lock word reports that state in bit 16. The control word drives two outputs. One is a registered remap enable that keeps the boot flash visible at address zero. The other is a single-cycle system reset request. The installed memory size is a parameter that sets a size code in the SDRAM word and a density byte in the presence-detect data.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, the words read as follows: main oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init 0x00000112, and SDRAM 0x00011122 ORed with the size code. The size code is 0x10 for MEM_MB at or above 256, 0x0C at or above 128, 0x08 at or above 64, 0x04 at or above 32, and 0 below 32. Control, lock and both flag words read 0. At reset, remap_en is 1, reset_req is 0 and bus_rdata is 0.
- R2: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000. Writes to these words change nothing.
- R3: A write to word 5 (lock) stores bits 15:0 of the data. The lock word reads as 0x0001A05F while it holds 0xA05F, and reads as its stored value otherwise.
- R4: Writes to word 2 (main oscillator) and word 7 (auxiliary oscillator) update the word only while the lock holds 0xA05F. Otherwise they are dropped.
- R5: A write to word 3 (control) stores only data bits 0 and 2. Every other bit of the control word, bit 3 included, reads as 0.
- R6: A write to word 3 with data bit 3 set raises reset_req for exactly the one cycle after the write.
- R7: remap_en equals the inverse of the stored control bit 2 and updates on the clock edge that takes the write.
- R8: A write to word 12 ORs the data into the flags word, and a write to word 13 clears the flag bits written as 1. Words 14 and 15 act the same way on the non-volatile flags word, which reads at word 14. Words 13 and 15 read 0.
- R9: Word 8 (SDRAM) and word 9 (init) store full 32-bit writes.
- R10: Word 10 returns a counter that starts at 0 on reset and advances by one every TICK_DIV clock cycles, modulo 2^CNT_W. Two reads taken N·TICK_DIV cycles apart differ by N.
- R11: Word 64+k, for k from 0 to 31, returns presence-detect byte k, zero-extended. The bytes are the fixed header listed in the RTL, with byte 31 replaced by the density code: 64, 32, 16, 4 or 2 for the same MEM_MB thresholds as R1. Words 96 to 127 read 0.
- R12: Every other word, the voltage words 32 to 35 included, reads 0. Writes to these words change no register and no output.
- R13: bus_rdata takes the addressed value on the clock edge where bus_re is high, and holds its value on all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| remap_en | output | 1 | Boot flash alias at address zero enabled |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
After every group of writes, the bench reads the whole 128-word map and compares each word against a model that it updates from the requirements alone. A design that lets an oscillator write through while locked, or that drops one while unlocked, shows up as a wrong word in the sweep. So does a lock readback without bit 16, and so does a stray write to an undefined word that lands on a real register. The reset bit is checked at the cycle level: a design that stores bit 3, or that holds reset_req for more than one cycle, fails there. The counter is read at exact multiples of the divider period, so an off-by-one divider gives the wrong difference.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 7;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] waddr_t;

  // word map
  localparam waddr_t W_IDENT    = 7'd0;
  localparam waddr_t W_PROC     = 7'd1;
  localparam waddr_t W_OSC      = 7'd2;
  localparam waddr_t W_CTRL     = 7'd3;
  localparam waddr_t W_STAT     = 7'd4;
  localparam waddr_t W_LOCK     = 7'd5;
  localparam waddr_t W_AUX      = 7'd7;
  localparam waddr_t W_SDRAM    = 7'd8;
  localparam waddr_t W_INIT     = 7'd9;
  localparam waddr_t W_REFCNT   = 7'd10;
  localparam waddr_t W_FLG_SET  = 7'd12;
  localparam waddr_t W_FLG_CLR  = 7'd13;
  localparam waddr_t W_NVF_SET  = 7'd14;
  localparam waddr_t W_NVF_CLR  = 7'd15;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam word_t IDENT_VAL = 32'h411A_3001;
  localparam word_t STAT_VAL  = 32'h0010_0000;
  localparam word_t OSC_RST   = 32'h0100_0048;
  localparam word_t AUX_RST   = 32'h0007_FEFF;
  localparam word_t SDRAM_RST = 32'h0001_1122;
  localparam word_t INIT_RST  = 32'h0000_0112;

  // control bits that are stored
  localparam int unsigned CTRL_LED_BIT   = 0;
  localparam int unsigned CTRL_REMAP_BIT = 2;
  localparam int unsigned CTRL_RST_BIT   = 3;

  function automatic logic [7:0] size_code(input int mb);
    if (mb >= 256)     return 8'h10;
    else if (mb >= 128) return 8'h0C;
    else if (mb >= 64)  return 8'h08;
    else if (mb >= 32)  return 8'h04;
    else                return 8'h00;
  endfunction

  function automatic logic [7:0] density_code(input int mb);
    if (mb >= 256)     return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction
endpackage

// File: rtl/sysctl_refcnt.sv
module sysctl_refcnt #(
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)            div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DIV_LAST);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/sysctl_spd.sv
module sysctl_spd #(
  parameter int MEM_MB = 128
) (
  input  logic [4:0] idx,
  output logic [7:0] data
);
  import sysctl_pkg::*;
  localparam logic [7:0] DENSITY = density_code(MEM_MB);

  always_comb begin
    case (idx)
      5'd0:  data = 8'd128;
      5'd1:  data = 8'd8;
      5'd2:  data = 8'd4;
      5'd3:  data = 8'd11;
      5'd4:  data = 8'd9;
      5'd5:  data = 8'd1;
      5'd6:  data = 8'd64;
      5'd8:  data = 8'd2;
      5'd9:  data = 8'hA0;
      5'd10: data = 8'hA0;
      5'd13: data = 8'd8;
      5'd15: data = 8'd1;
      5'd16: data = 8'h0E;
      5'd17: data = 8'd4;
      5'd18: data = 8'h1C;
      5'd19: data = 8'd1;
      5'd20: data = 8'd2;
      5'd21: data = 8'h20;
      5'd22: data = 8'hC0;
      5'd27: data = 8'h30;
      5'd28: data = 8'h28;
      5'd29: data = 8'h30;
      5'd30: data = 8'h28;
      5'd31: data = DENSITY;
      default: data = 8'd0;
    endcase
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter int MEM_MB   = 128,
  parameter int TICK_DIV = 4,
  parameter int CNT_W    = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [6:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        remap_en,
  output logic        reset_req
);
  import sysctl_pkg::*;

  localparam word_t SDRAM_INIT = SDRAM_RST | word_t'(size_code(MEM_MB));
  localparam word_t CTRL_MASK  = word_t'((1 << CTRL_LED_BIT) | (1 << CTRL_REMAP_BIT));

  word_t       osc_q, aux_q, ctrl_q, sdram_q, init_q, flags_q, nvflags_q;
  logic [15:0] lock_q;
  logic        unlocked;
  logic [CNT_W-1:0] refcnt;
  logic [7:0]  spd_byte;
  word_t       rd_val;

  assign unlocked = (lock_q == UNLOCK_KEY);

  sysctl_refcnt #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_refcnt (
    .clk(clk), .rst(rst), .count(refcnt)
  );

  sysctl_spd #(.MEM_MB(MEM_MB)) u_spd (
    .idx(bus_addr[4:0]), .data(spd_byte)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q     <= OSC_RST;
      aux_q     <= AUX_RST;
      ctrl_q    <= '0;
      lock_q    <= '0;
      sdram_q   <= SDRAM_INIT;
      init_q    <= INIT_RST;
      flags_q   <= '0;
      nvflags_q <= '0;
      remap_en  <= 1'b1;
    end else if (bus_we) begin
      case (bus_addr)
        W_OSC:     if (unlocked) osc_q <= bus_wdata;
        W_AUX:     if (unlocked) aux_q <= bus_wdata;
        W_CTRL: begin
          ctrl_q   <= bus_wdata & CTRL_MASK;
          remap_en <= ~bus_wdata[CTRL_REMAP_BIT];
        end
        W_LOCK:    lock_q    <= bus_wdata[15:0];
        W_SDRAM:   sdram_q   <= bus_wdata;
        W_INIT:    init_q    <= bus_wdata;
        W_FLG_SET: flags_q   <= flags_q | bus_wdata;
        W_FLG_CLR: flags_q   <= flags_q & ~bus_wdata;
        W_NVF_SET: nvflags_q <= nvflags_q | bus_wdata;
        W_NVF_CLR: nvflags_q <= nvflags_q & ~bus_wdata;
        default: ;
      endcase
    end
  end

  // single-cycle reset request
  always_ff @(posedge clk) begin
    if (rst) reset_req <= 1'b0;
    else     reset_req <= bus_we && (bus_addr == W_CTRL) && bus_wdata[CTRL_RST_BIT];
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (bus_addr[6:5] == 2'b10) begin
      rd_val = word_t'(spd_byte);
    end else if (bus_addr[6] == 1'b0) begin
      case (bus_addr)
        W_IDENT:   rd_val = IDENT_VAL;
        W_STAT:    rd_val = STAT_VAL;
        W_OSC:     rd_val = osc_q;
        W_CTRL:    rd_val = ctrl_q;
        W_LOCK:    rd_val = unlocked ? {15'd0, 1'b1, lock_q} : {16'd0, lock_q};
        W_AUX:     rd_val = aux_q;
        W_SDRAM:   rd_val = sdram_q;
        W_INIT:    rd_val = init_q;
        W_REFCNT:  rd_val = word_t'(refcnt);
        W_FLG_SET: rd_val = flags_q;
        W_NVF_SET: rd_val = nvflags_q;
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_we,
  input logic        bus_re,
  input logic [6:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        remap_en,
  input logic        reset_req
);
  // R6
  reset_src_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(bus_we && bus_addr == 7'd3 && bus_wdata[3]));

  // R6
  reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |=> !reset_req);

  // R7
  remap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we && bus_addr == 7'd3) |-> $stable(remap_en));

  // R7
  remap_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_we && bus_addr == 7'd3) |-> (remap_en == !$past(bus_wdata[2])));

  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_re) |-> $stable(bus_rdata));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .remap_en(remap_en), .reset_req(reset_req)
);

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
  localparam int MEM_MB = 128;
  localparam int DIV    = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        remap_en, reset_req;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  sysctl_regs #(.MEM_MB(MEM_MB), .TICK_DIV(DIV), .CNT_W(32)) u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .remap_en(remap_en), .reset_req(reset_req)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // model state from the requirements
  logic [31:0] m_osc, m_aux, m_ctrl, m_sdram, m_init, m_flags, m_nv;
  logic [15:0] m_lock;
  logic [7:0]  spd_hdr [32];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int w);
    if (w >= 64 && w < 96) return {24'd0, spd_hdr[w-64]};
    case (w)
      0: return 32'h411A3001;
      4: return 32'h00100000;
      2: return m_osc;
      3: return m_ctrl;
      5: return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'd0, m_lock};
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      12: return m_flags;
      14: return m_nv;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int w);
    if (w >= 64 && w < 96) return "R11";
    case (w)
      0, 1, 4: return "R2";
      2, 7: return "R4";
      3: return "R5";
      5: return "R3";
      8, 9: return "R9";
      12, 13, 14, 15: return "R8";
      default: return "R12";
    endcase
  endfunction

  // tasks are entered just after a falling edge
  task automatic wr(input int w, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = 7'(w); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    case (w)
      2: if (m_lock == 16'hA05F) m_osc = d;
      7: if (m_lock == 16'hA05F) m_aux = d;
      3: m_ctrl = d & 32'h5;
      5: m_lock = d[15:0];
      8: m_sdram = d;
      9: m_init = d;
      12: m_flags = m_flags | d;
      13: m_flags = m_flags & ~d;
      14: m_nv = m_nv | d;
      15: m_nv = m_nv & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input int w, output logic [31:0] v, output int stamp);
    bus_re = 1'b1; bus_addr = 7'(w);
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
    stamp = cyc;
  endtask

  task automatic sweep();
    logic [31:0] v;
    int s;
    for (int w = 0; w < 128; w++) begin
      if (w != 10) begin
        rd(w, v, s);
        check(tag_of(w), v, exp_word(w));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    int sa, sb;
    spd_hdr = '{8'd128, 8'd8, 8'd4, 8'd11, 8'd9, 8'd1, 8'd64, 8'd0,
                8'd2, 8'hA0, 8'hA0, 8'd0, 8'd0, 8'd8, 8'd0, 8'd1,
                8'h0E, 8'd4, 8'h1C, 8'd1, 8'd2, 8'h20, 8'hC0, 8'd0,
                8'd0, 8'd0, 8'd0, 8'h30, 8'h28, 8'h30, 8'h28, 8'd32};
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_ctrl = 0; m_lock = 0;
    m_sdram = 32'h0001112E; m_init = 32'h00000112; m_flags = 0; m_nv = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state of outputs
    check("R1 remap_en", {31'd0, remap_en}, 32'd1);
    check("R1 reset_req", {31'd0, reset_req}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    sweep(); // R1 R2 R11 R12

    // R4 locked: oscillator writes dropped; R2 constant words untouched
    wr(2, 32'hDEADBEEF); wr(7, 32'h12345678);
    wr(0, 32'hFFFFFFFF); wr(4, 32'h0);
    wr(5, 32'h0000A05E);
    wr(2, 32'h0BADF00D);
    sweep();

    // R3 unlock, key in low half only
    wr(5, 32'hFFFFA05F);
    rd(5, a, sa); check("R3 unlocked read", a, 32'h0001A05F);
    wr(2, 32'hCAFE0001); wr(7, 32'hCAFE0007);
    sweep();
    wr(5, 32'h00001234);
    rd(5, a, sa); check("R3 locked read", a, 32'h00001234);
    wr(2, 32'h55555555); wr(7, 32'hAAAAAAAA);
    sweep(); // R4 relocked

    // R5 R6 R7 control word
    wr(3, 32'hFFFFFFFF);
    check("R6 pulse high", {31'd0, reset_req}, 32'd1);
    check("R7 remap off", {31'd0, remap_en}, 32'd0);
    @(negedge clk);
    check("R6 pulse low", {31'd0, reset_req}, 32'd0);
    rd(3, a, sa); check("R5 ctrl bits", a, 32'h5);
    wr(3, 32'h00000001);
    check("R6 no pulse", {31'd0, reset_req}, 32'd0);
    check("R7 remap on", {31'd0, remap_en}, 32'd1);
    wr(3, 32'h00000008);
    check("R6 bit3 alone", {31'd0, reset_req}, 32'd1);
    check("R7 remap kept", {31'd0, remap_en}, 32'd1);
    sweep();

    // R8 flags, R9 sdram/init
    wr(12, 32'hF0F0000F); wr(12, 32'h00000F00); wr(13, 32'h10100003);
    wr(14, 32'h80000001); wr(15, 32'h00000001); wr(14, 32'h00FF0000);
    wr(8, 32'h13572468); wr(9, 32'hFFFF0000);
    sweep();

    // R12 undefined words: all-ones writes change nothing
    for (int w = 0; w < 128; w++) begin
      if (w == 6 || w == 11 || (w >= 16 && w != 10) && !(w >= 64 && w < 96) || (w >= 64))
        wr(w, 32'hFFFFFFFF);
    end
    check("R12 reset_req quiet", {31'd0, reset_req}, 32'd0);
    check("R12 remap quiet", {31'd0, remap_en}, 32'd1);
    sweep();

    // R10 reference counter
    for (int gap = 40; gap <= 120; gap += 40) begin
      rd(10, a, sa);
      while (!(((cyc + 1 - sa) % DIV) == 0 && (cyc + 1 - sa) >= gap)) @(negedge clk);
      rd(10, b, sb);
      check("R10 counter delta", b - a, 32'((sb - sa) / DIV));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule